// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block keeps, for each channel of a four-channel DMA controller, a 16-bit base address, a 16-bit base count, a current address, a progress counter and an address direction bit. Software reaches the base registers through a byte-wide port. One byte-pointer flip-flop, shared by all channels, decides whether an access touches the low or the high byte. A transfer engine pulses one advance strobe per channel for every unit it moves. Readback does not return stored values. It computes the live address and the remaining count from the current address, the base count and the progress.

A static mode input chooses byte mode or word mode. In word mode the register index comes from the port address shifted right by one. The current address holds the base shifted left by one. Readback drops the lowest bit of the computed value. A clear pulse and a master-clear pulse from the control decoder force the byte pointer back to the low byte.

Top module: `dma_addr_regfile`

## Requirements
- R1: The 4-bit register index is port_addr[3:0] in byte mode and port_addr[4:1] in word mode. Index bits [3:1] name the channel and bit 0 selects address (0) or count (1). An access whose channel number is NCH or higher is ignored: no register changes, the byte pointer keeps its value and rd_data holds.
- R2: Every accepted access uses the byte pointer as it stands (0 = low byte, 1 = high byte) and then toggles it. The pointer is 0 after reset.
- R3: A low-byte write replaces bits [7:0] of the selected base register. A high-byte write replaces bits [15:8].
- R4: A high-byte write to either register of a channel re-initialises that channel. The current address becomes the new base address (shifted left by one in word mode) and the progress becomes 0. This wins over an advance strobe for that channel in the same cycle.
- R5: An address read computes current address plus progress, modulo 2^17. When the channel's direction bit is 1 it computes current address minus progress instead. mode_we writes mode_down into the channel named by mode_chan.
- R6: A count read computes the base count (shifted left by one in word mode) minus the progress, modulo 2^17.
- R7: The byte returned is computed value bits [s+8p+7 : s+8p], where s is 1 in word mode and 0 otherwise, and p is the byte pointer. rd_data is registered: it changes in the cycle after a read and holds at all other times.
- R8: ptr_clear or master_clear forces the byte pointer to 0. Either one takes priority over a toggle from an access in the same cycle.
- R9: Each adv strobe adds 1 to that channel's progress until the progress reaches the length, which is base count + 1. Beyond that point it holds. ch_done[k] is 1 in the cycle after channel k's progress is at or above its length.
- R10: The synchronous reset clears all base, current, progress and direction registers, the byte pointer, rd_data and ch_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 selects word mode |
| acc_en | input | 1 | Port access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| port_addr | input | 5 | Port address |
| wr_data | input | 8 | Write byte |
| mode_we | input | 1 | Direction bit write strobe |
| mode_chan | input | 2 | Channel for the direction write |
| mode_down | input | 1 | Direction bit: 1 = address decrements |
| ptr_clear | input | 1 | Byte-pointer clear pulse |
| master_clear | input | 1 | Master-clear pulse (clears the pointer) |
| adv | input | 4 | Per-channel progress advance strobes |
| rd_data | output | 8 | Registered read byte |
| ch_done | output | 4 | Per-channel progress reached length |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a high-byte write that re-initialises a channel and an advance strobe for that same channel. The bench drives both on one edge and then expects the count readback to equal the unmodified base count, which shows the progress was cleared rather than incremented. The second pair is a pointer clear and a register access. The bench drives them together and then checks that the next access still returns the low byte.

// File: rtl/dmarf_pkg.sv
package dmarf_pkg;
  localparam int BASE_W = 16;
  localparam int VAL_W  = BASE_W + 1;
  localparam int IDX_W  = 4;
  localparam int PORT_W = IDX_W + 1;

  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_CNT  = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic       hit;
    logic [2:0] chan;
    reg_sel_e   sel;
  } port_dec_t;
endpackage

// File: rtl/dmarf_decode.sv
module dmarf_decode
  import dmarf_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              wide,
  input  logic [PORT_W-1:0] port_addr,
  output port_dec_t         dec
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    idx      = wide ? port_addr[PORT_W-1:1] : port_addr[IDX_W-1:0];
    dec.chan = idx[3:1];
    dec.sel  = reg_sel_e'(idx[0]);
    dec.hit  = ({29'd0, idx[3:1]} < NCH);
  end
endmodule

// File: rtl/dmarf_byteptr.sv
module dmarf_byteptr (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic ptr
);
  always_ff @(posedge clk) begin
    if (rst || clr) ptr <= 1'b0;
    else if (step)  ptr <= ~ptr;
  end
endmodule

// File: rtl/dmarf_chan.sv
module dmarf_chan
  import dmarf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wide,
  input  logic             wr_en,
  input  reg_sel_e         wr_sel,
  input  logic             wr_hi,
  input  logic [7:0]       wr_data,
  input  logic             dir_we,
  input  logic             dir_in,
  input  logic             adv,
  output logic [VAL_W-1:0] addr_val,
  output logic [VAL_W-1:0] cnt_val,
  output logic             done
);
  logic [BASE_W-1:0] base_a, base_c, base_a_d, base_c_d;
  logic [VAL_W-1:0]  cur_a, prog, cur_d, prog_d, len_q, len_d;
  logic              dir_q, reinit;

  always_comb begin
    base_a_d = base_a;
    base_c_d = base_c;
    if (wr_en) begin
      if (wr_sel == SEL_ADDR) begin
        if (wr_hi) base_a_d[15:8] = wr_data;
        else       base_a_d[7:0]  = wr_data;
      end else begin
        if (wr_hi) base_c_d[15:8] = wr_data;
        else       base_c_d[7:0]  = wr_data;
      end
    end
    reinit = wr_en && wr_hi;
    len_q  = {1'b0, base_c} + 1'b1;
    len_d  = {1'b0, base_c_d} + 1'b1;
    if (reinit)                 prog_d = '0;
    else if (adv && prog < len_q) prog_d = prog + 1'b1;
    else                        prog_d = prog;
    if (reinit) cur_d = wide ? {base_a_d, 1'b0} : {1'b0, base_a_d};
    else        cur_d = cur_a;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_a <= '0;
      base_c <= '0;
      cur_a  <= '0;
      prog   <= '0;
      dir_q  <= 1'b0;
      done   <= 1'b0;
    end else begin
      base_a <= base_a_d;
      base_c <= base_c_d;
      cur_a  <= cur_d;
      prog   <= prog_d;
      done   <= (prog_d >= len_d);
      if (dir_we) dir_q <= dir_in;
    end
  end

  always_comb begin
    addr_val = dir_q ? (cur_a - prog) : (cur_a + prog);
    cnt_val  = (wide ? {base_c, 1'b0} : {1'b0, base_c}) - prog;
  end
endmodule

// File: rtl/dmarf_readmux.sv
module dmarf_readmux
  import dmarf_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd_stb,
  input  logic                      wide,
  input  logic                      ptr,
  input  port_dec_t                 dec,
  input  logic [NCH-1:0][VAL_W-1:0] addr_v,
  input  logic [NCH-1:0][VAL_W-1:0] cnt_v,
  output logic [7:0]                rd_data
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [VAL_W-1:0] val;
  logic [7:0]       byte_sel;
  logic [CH_W-1:0]  ch;

  always_comb begin
    ch  = dec.chan[CH_W-1:0];
    val = (dec.sel == SEL_CNT) ? cnt_v[ch] : addr_v[ch];
    case ({wide, ptr})
      2'b00:   byte_sel = val[7:0];
      2'b01:   byte_sel = val[15:8];
      2'b10:   byte_sel = val[8:1];
      default: byte_sel = val[16:9];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= 8'h00;
    else if (rd_stb) rd_data <= byte_sel;
  end
endmodule

// File: rtl/dma_addr_regfile.sv
module dma_addr_regfile
  import dmarf_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_mode,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [PORT_W-1:0] port_addr,
  input  logic [7:0]        wr_data,
  input  logic              mode_we,
  input  logic [CH_W-1:0]   mode_chan,
  input  logic              mode_down,
  input  logic              ptr_clear,
  input  logic              master_clear,
  input  logic [NCH-1:0]    adv,
  output logic [7:0]        rd_data,
  output logic [NCH-1:0]    ch_done
);
  port_dec_t                 dec;
  logic                      accept, byte_ptr;
  logic [NCH-1:0][VAL_W-1:0] addr_v, cnt_v;

  dmarf_decode #(.NCH(NCH)) u_dec (
    .wide(wide_mode), .port_addr(port_addr), .dec(dec)
  );

  assign accept = acc_en && dec.hit;

  dmarf_byteptr u_ptr (
    .clk(clk), .rst(rst), .clr(ptr_clear || master_clear),
    .step(accept), .ptr(byte_ptr)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic sel_k;
    assign sel_k = accept && acc_wr && ({29'd0, dec.chan} == k);
    dmarf_chan u_chan (
      .clk(clk), .rst(rst), .wide(wide_mode),
      .wr_en(sel_k), .wr_sel(dec.sel), .wr_hi(byte_ptr), .wr_data(wr_data),
      .dir_we(mode_we && ({{(32-CH_W){1'b0}}, mode_chan} == k)),
      .dir_in(mode_down), .adv(adv[k]),
      .addr_val(addr_v[k]), .cnt_val(cnt_v[k]), .done(ch_done[k])
    );
  end

  dmarf_readmux #(.NCH(NCH)) u_rd (
    .clk(clk), .rst(rst), .rd_stb(accept && !acc_wr), .wide(wide_mode),
    .ptr(byte_ptr), .dec(dec), .addr_v(addr_v), .cnt_v(cnt_v),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/dmarf_checker.sv
module dmarf_checker #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           acc_wr,
  input logic           ptr_clear,
  input logic           master_clear,
  input logic           accept,
  input logic           byte_ptr,
  input logic [2:0]     chan,
  input logic [7:0]     rd_data,
  input logic [NCH-1:0] ch_done
);
  logic clr;
  assign clr = ptr_clear || master_clear;

  p_ptr_clear_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> !byte_ptr);

  p_ptr_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && !clr) |=> (byte_ptr != $past(byte_ptr)));

  p_ptr_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (!accept && !clr) |=> $stable(byte_ptr));

  p_rd_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(accept && !acc_wr) |=> $stable(rd_data));

  for (genvar k = 0; k < NCH; k++) begin : g_a
    p_reinit_r4: assert property (@(posedge clk) disable iff (rst)
      (accept && acc_wr && byte_ptr && ({29'd0, chan} == k)) |=> !ch_done[k]);
    p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (ch_done[k] && !(accept && acc_wr)) |=> ch_done[k]);
  end
endmodule

bind dma_addr_regfile dmarf_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .acc_wr(acc_wr), .ptr_clear(ptr_clear),
  .master_clear(master_clear), .accept(accept), .byte_ptr(byte_ptr),
  .chan(dec.chan), .rd_data(rd_data), .ch_done(ch_done)
);

// File: tb/dma_addr_regfile_test.sv
module dma_addr_regfile_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wide_mode = 1'b0, acc_en = 1'b0, acc_wr = 1'b0;
  logic [4:0] port_addr = '0;
  logic [7:0] wr_data = '0;
  logic       mode_we = 1'b0, mode_down = 1'b0;
  logic [1:0] mode_chan = '0;
  logic       ptr_clear = 1'b0, master_clear = 1'b0;
  logic [3:0] adv = '0;
  logic [7:0] rd_data;
  logic [3:0] ch_done;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma_addr_regfile uut (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .acc_en(acc_en),
    .acc_wr(acc_wr), .port_addr(port_addr), .wr_data(wr_data),
    .mode_we(mode_we), .mode_chan(mode_chan), .mode_down(mode_down),
    .ptr_clear(ptr_clear), .master_clear(master_clear), .adv(adv),
    .rd_data(rd_data), .ch_done(ch_done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] pa, input logic [7:0] d);
    @(negedge clk);
    acc_en = 1; acc_wr = 1; port_addr = pa; wr_data = d;
    @(negedge clk);
    acc_en = 0; acc_wr = 0;
  endtask

  task automatic rd_chk(input logic [4:0] pa, input int exp, input string req);
    @(negedge clk);
    acc_en = 1; acc_wr = 0; port_addr = pa;
    @(negedge clk);
    acc_en = 0;
    check(req, rd_data, exp);
  endtask

  task automatic step_adv(input logic [3:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); adv = m;
      @(negedge clk); adv = 0;
    end
  endtask

  task automatic t_reset;
    check("R10 rd_data after reset", rd_data, 0);
    check("R10 ch_done after reset", ch_done, 0);
    rd_chk(5'd0, 8'h00, "R10 ch0 addr low after reset");
    rd_chk(5'd0, 8'h00, "R10 ch0 addr high after reset");
  endtask

  task automatic t_bytes;
    wr(5'd2, 8'h34); wr(5'd2, 8'h12);
    rd_chk(5'd2, 8'h34, "R3 ch1 addr low byte");
    rd_chk(5'd2, 8'h12, "R3 ch1 addr high byte");
  endtask

  task automatic t_count;
    wr(5'd3, 8'h03); wr(5'd3, 8'h00);
    step_adv(4'b0010, 2);
    rd_chk(5'd3, 8'h01, "R6 ch1 remaining count low");
    rd_chk(5'd3, 8'h00, "R6 ch1 remaining count high");
    rd_chk(5'd2, 8'h36, "R5 ch1 incrementing addr low");
    rd_chk(5'd2, 8'h12, "R5 ch1 incrementing addr high");
  endtask

  task automatic t_dir;
    @(negedge clk); mode_we = 1; mode_chan = 2'd1; mode_down = 1;
    @(negedge clk); mode_we = 0;
    rd_chk(5'd2, 8'h32, "R5 ch1 decrementing addr low");
    rd_chk(5'd2, 8'h12, "R5 ch1 decrementing addr high");
  endtask

  task automatic t_sat;
    step_adv(4'b0010, 5);
    check("R9 ch1 done at saturation", ch_done, 4'b0010);
    rd_chk(5'd3, 8'hFF, "R9 saturated count low");
    rd_chk(5'd3, 8'hFF, "R9 saturated count high");
    rd_chk(5'd2, 8'h30, "R9 saturated addr low");
    rd_chk(5'd2, 8'h12, "R9 saturated addr high");
  endtask

  task automatic t_reinit;
    wr(5'd3, 8'h03); wr(5'd3, 8'h00);
    check("R4 done cleared by reinit", ch_done, 0);
    rd_chk(5'd3, 8'h03, "R4 count after reinit low");
    rd_chk(5'd3, 8'h00, "R4 count after reinit high");
    step_adv(4'b0010, 1);
    wr(5'd3, 8'h03);
    @(negedge clk);
    acc_en = 1; acc_wr = 1; port_addr = 5'd3; wr_data = 8'h00; adv = 4'b0010;
    @(negedge clk);
    acc_en = 0; acc_wr = 0; adv = 0;
    rd_chk(5'd3, 8'h03, "R4 reinit wins over advance");
    rd_chk(5'd3, 8'h00, "R4 reinit wins over advance high");
  endtask

  task automatic t_clear;
    wr(5'd4, 8'h55);
    @(negedge clk); ptr_clear = 1;
    @(negedge clk); ptr_clear = 0;
    wr(5'd4, 8'h66); wr(5'd4, 8'h77);
    rd_chk(5'd4, 8'h66, "R8 clear returns pointer to low");
    rd_chk(5'd4, 8'h77, "R8 high after clear");
    @(negedge clk); acc_en = 1; acc_wr = 0; port_addr = 5'd4; ptr_clear = 1;
    @(negedge clk); acc_en = 0; ptr_clear = 0;
    check("R8 read with clear uses low", rd_data, 8'h66);
    rd_chk(5'd4, 8'h66, "R8 clear beats toggle");
    rd_chk(5'd4, 8'h77, "R2 pointer toggles to high");
  endtask

  task automatic t_master;
    wr(5'd6, 8'h11);
    @(negedge clk); master_clear = 1;
    @(negedge clk); master_clear = 0;
    wr(5'd6, 8'h22); wr(5'd6, 8'h33);
    rd_chk(5'd6, 8'h22, "R8 master clear low");
    rd_chk(5'd6, 8'h33, "R8 master clear high");
  endtask

  task automatic t_ignored;
    wr(5'd9, 8'hAA);
    rd_chk(5'd9, 8'h33, "R1 out-of-range read leaves rd_data");
    rd_chk(5'd6, 8'h22, "R1 pointer unchanged after ignored access");
    rd_chk(5'd6, 8'h33, "R1 ch3 addr high intact");
  endtask

  task automatic t_wide;
    @(negedge clk); wide_mode = 1;
    wr(5'd2, 8'h10); wr(5'd2, 8'h00);
    wr(5'd0, 8'h01); wr(5'd0, 8'h80);
    step_adv(4'b0001, 2);
    rd_chk(5'd0, 8'h02, "R7 word mode addr low");
    rd_chk(5'd1, 8'h80, "R1 word mode addr high via bit0 ignored");
    rd_chk(5'd2, 8'h0F, "R6 word mode count low");
    rd_chk(5'd2, 8'h00, "R6 word mode count high");
    check("R9 ch0 not done", ch_done[0], 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset(); t_bytes(); t_count(); t_dir(); t_sat(); t_reinit();
    t_clear(); t_master(); t_ignored(); t_wide();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule